// File: doc/BRIEF.md
# Coherent DMA Invalidation Tracker

This block follows an external DMA master while it owns a shared multiplexed address/data bus. It keeps the data cache coherent with memory that the DMA master overwrites. The master asks for the bus on a request input, and the block answers with a registered grant. While the grant is held and the master signals that coherency is needed, the block takes the write target address off the bus at the address strobe of a write. It then advances that address by one word on every acknowledged write transfer.

Whenever the master raises its invalidate request, the block issues one single-cycle invalidate command. The command carries the cache line index of the current target address, which is the word address with its word-in-line offset bits removed. Dropping the grant at the end of the tenure clears the captured address. A new tenure must therefore capture again before any invalidate can be issued.

Top module: `cinv_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `bus_gnt_o` and `inv_valid_o` are low.
- R2: `bus_gnt_o` equals the value `bus_req_i` had at the previous rising clock edge.
- R3: While granted and `coh_req_i` is high, a cycle with `ale_i` and `wr_i` both high loads the target address from `ad_i`. Values on `ad_i` in other cycles are not used.
- R4: While granted, with `coh_req_i` high and an address captured, each cycle with `ack_i` and `wr_i` high and `ale_i` low advances the target address by one, wrapping modulo 2^ADDR_W. An acknowledge with `wr_i` low, or one given before any capture, has no effect.
- R5: The line index on `inv_line_o` is the target address shifted right by log2(LINE_WORDS) bits. It is taken from the address as it stood before any acknowledge in the same cycle.
- R6: A rising edge on `ivd_req_i` that is seen while granted, with `coh_req_i` high and an address captured, makes `inv_valid_o` high for exactly the next cycle. A request that stays high does not pulse again.
- R7: While `coh_req_i` is low, no capture, no address increment and no invalidate take place. The captured address is kept.
- R8: A cycle without grant clears the captured address. After a new grant, invalidate requests produce no command until a new capture is made.
- R9: When `ale_i` and `ack_i` are high in the same write cycle, the capture wins and the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | External master asks for the bus |
| bus_gnt_o | output | 1 | Bus released to the external master |
| coh_req_i | input | 1 | Current DMA needs hardware coherency |
| ale_i | input | 1 | Address strobe: `ad_i` holds an address |
| wr_i | input | 1 | Current transfer is a write |
| ack_i | input | 1 | Current transfer completed |
| ivd_req_i | input | 1 | Invalidate the line of the current target |
| ad_i | input | ADDR_W | Multiplexed address/data bus (word address) |
| inv_valid_o | output | 1 | One-cycle line invalidate command |
| inv_line_o | output | ADDR_W-log2(LINE_WORDS) | Line index of the command |

## Verification
The grant and the invalidate command are both one register away from their inputs. Each is due on the first rising edge after the stimulus, so the bench drives on falling edges and samples on the next falling edge. An address capture or an acknowledge changes only internal state. Its effect is read one cycle later as the line index of an invalidate raised on the following falling edge. A held request is sampled one further cycle on to confirm that no second pulse appears. Start addresses and acknowledge counts are swept over an 8-bit bus, and the expected index is computed as the wrapped sum shifted right by two.

// File: rtl/cinv_pkg.sv
package cinv_pkg;

  // Per-cycle bus strobes that steer the target address register.
  typedef struct packed {
    logic ale;
    logic wr;
    logic ack;
  } xfer_strobe_t;

  // Rising-edge detect on a sampled level.
  function automatic logic rise_of(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

endpackage

// File: rtl/cinv_grant.sv
module cinv_grant (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req_i,
  output logic bus_gnt_o
);

  logic gnt_d, gnt_q;

  always_comb begin
    gnt_d = bus_req_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gnt_q <= 1'b0;
    else        gnt_q <= gnt_d;
  end

  assign bus_gnt_o = gnt_q;

  p_gnt_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_i |=> bus_gnt_o);
  p_gnt_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req_i |=> !bus_gnt_o);

endmodule

// File: rtl/cinv_addr_track.sv
module cinv_addr_track
  import cinv_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_i,
  input  logic              coh_i,
  input  xfer_strobe_t      strb_i,
  input  logic [ADDR_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_ok_o
);

  logic [ADDR_W-1:0] cnt_d, cnt_q;
  logic              ok_d, ok_q;
  logic              active, do_cap, do_inc;

  always_comb begin
    active = gnt_i & coh_i;
    do_cap = active & strb_i.ale & strb_i.wr;
    do_inc = active & ok_q & strb_i.ack & strb_i.wr & ~strb_i.ale;
    cnt_d  = cnt_q;
    ok_d   = ok_q;
    if (!gnt_i) begin
      cnt_d = '0;
      ok_d  = 1'b0;
    end else if (do_cap) begin
      cnt_d = ad_i;
      ok_d  = 1'b1;
    end else if (do_inc) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign addr_o    = cnt_q;
  assign addr_ok_o = ok_q;

  p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_i && coh_i && strb_i.ale && strb_i.wr) |=> (addr_o == $past(ad_i)));
  p_ack_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_i && coh_i && ok_q && strb_i.ack && strb_i.wr && !strb_i.ale)
      |=> (addr_o == $past(addr_o) + 1'b1));
  p_hold_nocoh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_i && !coh_i) |=> $stable(addr_o));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_i |=> !addr_ok_o);

endmodule

// File: rtl/cinv_inv_pulse.sv
module cinv_inv_pulse
  import cinv_pkg::*;
#(
  parameter int IDX_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gnt_i,
  input  logic             coh_i,
  input  logic             addr_ok_i,
  input  logic             ivd_i,
  input  logic [IDX_W-1:0] line_i,
  output logic             inv_valid_o,
  output logic [IDX_W-1:0] inv_line_o
);

  logic             ivd_d, ivd_q;
  logic             vld_d, vld_q;
  logic [IDX_W-1:0] line_d, line_q;
  logic             fire;

  always_comb begin
    fire   = gnt_i & coh_i & addr_ok_i & rise_of(ivd_i, ivd_q);
    ivd_d  = gnt_i & ivd_i;
    vld_d  = fire;
    line_d = fire ? line_i : line_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ivd_q  <= 1'b0;
      vld_q  <= 1'b0;
      line_q <= '0;
    end else begin
      ivd_q  <= ivd_d;
      vld_q  <= vld_d;
      line_q <= line_d;
    end
  end

  assign inv_valid_o = vld_q;
  assign inv_line_o  = line_q;

  p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid_o |=> !inv_valid_o);
  p_held_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ivd_i && ivd_q) |=> !inv_valid_o);
  p_no_inv_nocoh_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !coh_i |=> !inv_valid_o);
  p_no_inv_nogrant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_ok_i |=> !inv_valid_o);

endmodule

// File: rtl/cinv_tracker.sv
module cinv_tracker
  import cinv_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int LINE_BITS = $clog2(LINE_WORDS),
  localparam int IDX_W     = ADDR_W - LINE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req_i,
  output logic              bus_gnt_o,
  input  logic              coh_req_i,
  input  logic              ale_i,
  input  logic              wr_i,
  input  logic              ack_i,
  input  logic              ivd_req_i,
  input  logic [ADDR_W-1:0] ad_i,
  output logic              inv_valid_o,
  output logic [IDX_W-1:0]  inv_line_o
);

  logic              gnt;
  logic [ADDR_W-1:0] tgt_addr;
  logic              tgt_ok;
  logic [IDX_W-1:0]  tgt_line;
  xfer_strobe_t      strb;

  always_comb begin
    strb.ale = ale_i;
    strb.wr  = wr_i;
    strb.ack = ack_i;
  end

  cinv_grant u_grant (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req_i (bus_req_i),
    .bus_gnt_o (gnt)
  );

  cinv_addr_track #(.ADDR_W(ADDR_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt_i     (gnt),
    .coh_i     (coh_req_i),
    .strb_i    (strb),
    .ad_i      (ad_i),
    .addr_o    (tgt_addr),
    .addr_ok_o (tgt_ok)
  );

  generate
    if (LINE_BITS == 0) begin : g_word_lines
      assign tgt_line = tgt_addr;
    end else begin : g_multi_word_lines
      assign tgt_line = tgt_addr[ADDR_W-1:LINE_BITS];
    end
  endgenerate

  cinv_inv_pulse #(.IDX_W(IDX_W)) u_pulse (
    .clk         (clk),
    .rst_n       (rst_n),
    .gnt_i       (gnt),
    .coh_i       (coh_req_i),
    .addr_ok_i   (tgt_ok),
    .ivd_i       (ivd_req_i),
    .line_i      (tgt_line),
    .inv_valid_o (inv_valid_o),
    .inv_line_o  (inv_line_o)
  );

  assign bus_gnt_o = gnt;

  p_line_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid_o |-> (inv_line_o == $past(tgt_line)));

endmodule

// File: tb/cinv_tracker_test.sv
module cinv_tracker_test;

  localparam int AW = 8;
  localparam int LW = 4;
  localparam int IW = AW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_req_i = 1'b0, coh_req_i = 1'b0;
  logic          ale_i = 1'b0, wr_i = 1'b0, ack_i = 1'b0, ivd_req_i = 1'b0;
  logic [AW-1:0] ad_i = '0;
  logic          bus_gnt_o, inv_valid_o;
  logic [IW-1:0] inv_line_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [AW-1:0] exp_addr;

  always #5 clk = ~clk;

  cinv_tracker #(.ADDR_W(AW), .LINE_WORDS(LW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .bus_gnt_o(bus_gnt_o),
    .coh_req_i(coh_req_i), .ale_i(ale_i), .wr_i(wr_i), .ack_i(ack_i),
    .ivd_req_i(ivd_req_i), .ad_i(ad_i), .inv_valid_o(inv_valid_o),
    .inv_line_o(inv_line_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [AW-1:0] a, input logic with_ack);
    @(negedge clk);
    ale_i = 1'b1; wr_i = 1'b1; ad_i = a; ack_i = with_ack;
    @(negedge clk);
    ale_i = 1'b0; ack_i = 1'b0; ad_i = a ^ 8'h5a;
  endtask

  task automatic acks(input int n, input logic wrv);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ack_i = 1'b1; wr_i = wrv;
      @(negedge clk);
      ack_i = 1'b0; wr_i = 1'b1;
    end
  endtask

  // Raise the invalidate request, check the pulse, hold it one more cycle.
  task automatic inv_probe(input string req, input logic exp_fire, input logic [AW-1:0] addr);
    @(negedge clk);
    ivd_req_i = 1'b1;
    @(negedge clk);
    chk(req, inv_valid_o, exp_fire);
    if (exp_fire) chk(req, inv_line_o, 32'(addr >> 2));
    @(negedge clk);
    chk({req, " R6 held"}, inv_valid_o, 1'b0);
    ivd_req_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 gnt in reset", bus_gnt_o, 1'b0);
    chk("R1 inv in reset", inv_valid_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 gnt after reset", bus_gnt_o, 1'b0);
    chk("R1 inv after reset", inv_valid_o, 1'b0);

    // R2 grant follows request by one edge
    bus_req_i = 1'b1;
    @(negedge clk);
    chk("R2 grant up", bus_gnt_o, 1'b1);
    coh_req_i = 1'b1; wr_i = 1'b1;

    // R8 no capture yet: no invalidate; R4 ack before capture ignored
    acks(2, 1'b1);
    inv_probe("R8 no capture", 1'b0, '0);

    // R3 R4 R5 R6 sweep of start addresses and ack counts
    for (int a = 0; a < 256; a++) begin
      for (int n = 0; n < 4; n++) begin
        capture(AW'(a), 1'b0);
        acks(n, 1'b1);
        acks(1, 1'b0);                  // R4 ack with wr low ignored
        exp_addr = AW'(a + n);
        inv_probe("R3 R4 R5 sweep", 1'b1, exp_addr);
      end
    end

    // R9 capture wins over same-cycle ack
    capture(8'h37, 1'b1);
    inv_probe("R9 ale beats ack", 1'b1, 8'h37);

    // R5 ack in the same cycle as the request edge: old address reported
    capture(8'h43, 1'b0);
    @(negedge clk);
    ack_i = 1'b1; ivd_req_i = 1'b1;
    @(negedge clk);
    ack_i = 1'b0;
    chk("R5 pre-ack valid", inv_valid_o, 1'b1);
    chk("R5 pre-ack line", inv_line_o, 32'(8'h43 >> 2));
    ivd_req_i = 1'b0;
    @(negedge clk);
    inv_probe("R5 post-ack", 1'b1, 8'h44);

    // R7 coherency off: capture, ack and invalidate all ignored, state kept
    capture(8'h80, 1'b0);
    coh_req_i = 1'b0;
    capture(8'hc0, 1'b0);
    acks(3, 1'b1);
    inv_probe("R7 coh low", 1'b0, '0);
    coh_req_i = 1'b1;
    inv_probe("R7 state kept", 1'b1, 8'h80);

    // R8 drop grant, regrant: captured address gone
    bus_req_i = 1'b0;
    @(negedge clk);
    chk("R2 grant down", bus_gnt_o, 1'b0);
    bus_req_i = 1'b1;
    @(negedge clk);
    chk("R2 regrant", bus_gnt_o, 1'b1);
    inv_probe("R8 cleared", 1'b0, '0);
    capture(8'hfd, 1'b0);
    acks(3, 1'b1);
    inv_probe("R8 R4 wrap after regrant", 1'b1, 8'h00);

    // R8 invalidate raised without grant does nothing
    bus_req_i = 1'b0;
    @(negedge clk);
    inv_probe("R8 no grant", 1'b0, '0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule